// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block collects eleven interrupt sources of a serial port and turns them into six interrupt request lines. Each source reaches the block as a one-cycle set strobe from the datapath; the strobe latches a sticky bit in a raw status word. Software sees that word, programs an enable mask, reads the raw word ANDed with the mask, and retires pending bits by writing ones to a clear register.

The six request lines group the enabled sources: one line carries every enabled source, four lines each carry a single receive, transmit or receive-timeout source or the modem-line group, and the last carries the line-error group. Interrupt controllers that want one wire per serial port use the combined line; those that route by cause use the others.

The register port is a plain single-cycle slave: a select, a write flag, a word index and write data. Read data is returned combinationally in the same cycle as the select.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the raw status word and the mask are zero and all six request lines are low.
- R2: A set strobe on source k makes raw bit k one from the next cycle; raw status reads at word index 15, with bit positions ring=0, clear-to-send=1, carrier-detect=2, data-set-ready=3, receive=4, transmit=5, receive-timeout=6, framing=7, parity=8, break=9, overrun=10, and zero above bit 10.
- R3: A write to word index 17 clears every raw bit whose written bit is one and leaves every other raw bit unchanged.
- R4: When a set strobe and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: The mask is written and read at word index 14 (bits above 10 are not stored and read zero); word index 16 reads raw status ANDed with the mask.
- R6: Request line 0 is high exactly when any raw bit is set whose mask bit is also set.
- R7: Request lines 1, 2 and 3 follow masked bits 4, 5 and 6; line 4 is the OR of masked bits 0 to 3; line 5 is the OR of masked bits 7 to 10.
- R8: The request lines are registered: a set strobe, clear write or mask write at one clock edge is reflected on the lines directly after that edge, and with none of these the lines hold their value.
- R9: Word index 17 reads zero, any index other than 14, 15 and 16 reads zero, writes to indices 15 and 16 change nothing, and read data is zero when the port is not selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 11 | Per-source set strobes from the datapath |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the select |
| irq_o | output | 6 | Request lines: combined, receive, transmit, timeout, modem group, error group |

## Verification
The bench aims at a strobe and a clear landing on the same bit, where a design giving priority to the clear would lose an interrupt, and at clears that carry a mix of ones and zeros, where a design clearing the whole word or the wrong bits would drop pending causes. It writes masks with upper bits set and writes to the read-only indices, which a sloppy decode would store or let corrupt the raw word. It compares the request lines every cycle against a behavioural model, so a swapped group member, an off-by-one bit position or an output that lags a mask write by an extra cycle shows up as a line mismatch.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int SRC_W   = 11;
   localparam int LINE_N  = 6;

   // source bit positions inside the raw status word
   localparam int B_RING  = 0;
   localparam int B_CTS   = 1;
   localparam int B_DCD   = 2;
   localparam int B_DSR   = 3;
   localparam int B_RXD   = 4;
   localparam int B_TXD   = 5;
   localparam int B_TOUT  = 6;
   localparam int B_FRAME = 7;
   localparam int B_PAR   = 8;
   localparam int B_BRK   = 9;
   localparam int B_OVR   = 10;

   typedef logic [SRC_W-1:0] src_vec_t;

   localparam src_vec_t GRP_MODEM = src_vec_t'((1 << B_RING) | (1 << B_CTS) |
                                               (1 << B_DCD)  | (1 << B_DSR));
   localparam src_vec_t GRP_ERR   = src_vec_t'((1 << B_FRAME) | (1 << B_PAR) |
                                               (1 << B_BRK)   | (1 << B_OVR));

   // which sources feed each request line
   function automatic src_vec_t line_sel(input int line);
      case (line)
         0:       line_sel = '1;
         1:       line_sel = src_vec_t'(1 << B_RXD);
         2:       line_sel = src_vec_t'(1 << B_TXD);
         3:       line_sel = src_vec_t'(1 << B_TOUT);
         4:       line_sel = GRP_MODEM;
         default: line_sel = GRP_ERR;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_raw.sv
module uart_irq_raw
   import uart_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t set_i,
   input  src_vec_t clr_vec,
   output src_vec_t raw_d,
   output src_vec_t raw_q
);

   // one sticky cell per source; a strobe outranks a clear
   for (genvar k = 0; k < SRC_W; k++) begin : g_cell
      assign raw_d[k] = set_i[k] | (raw_q[k] & ~clr_vec[k]);

      always_ff @(posedge clk) begin
         if (!rst_n) raw_q[k] <= 1'b0;
         else        raw_q[k] <= raw_d[k];
      end
   end

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 32,
   parameter int IDX_MASK = 14,
   parameter int IDX_RAW  = 15,
   parameter int IDX_MSKD = 16,
   parameter int IDX_CLR  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  src_vec_t          raw_q,
   output src_vec_t          mask_d,
   output src_vec_t          mask_q,
   output src_vec_t          clr_vec,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int PAD_W = DATA_W - SRC_W;

   logic     wr_en;
   logic     rd_en;
   src_vec_t wlo;
   src_vec_t rsel;
   logic     unused_hi;

   assign wr_en     = bus_sel & bus_wr;
   assign rd_en     = bus_sel & ~bus_wr;
   assign wlo       = bus_wdata[SRC_W-1:0];
   assign unused_hi = ^bus_wdata[DATA_W-1:SRC_W];

   assign mask_d  = (wr_en && bus_addr == ADDR_W'(IDX_MASK)) ? wlo : mask_q;
   assign clr_vec = (wr_en && bus_addr == ADDR_W'(IDX_CLR))  ? wlo : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   always_comb begin
      rsel = '0;
      if (rd_en) begin
         if (bus_addr == ADDR_W'(IDX_MASK))      rsel = mask_q;
         else if (bus_addr == ADDR_W'(IDX_RAW))  rsel = raw_q;
         else if (bus_addr == ADDR_W'(IDX_MSKD)) rsel = raw_q & mask_q;
      end
   end

   assign bus_rdata = {{PAD_W{1'b0}}, rsel};

endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
   import uart_irq_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  src_vec_t          raw_d,
   input  src_vec_t          mask_d,
   input  src_vec_t          raw_q,
   input  src_vec_t          mask_q,
   output logic [LINE_N-1:0] irq_o
);

   logic [LINE_N-1:0] line_nx;
   logic [LINE_N-1:0] line_now;

   for (genvar i = 0; i < LINE_N; i++) begin : g_line
      assign line_nx[i]  = |(raw_d & mask_d & line_sel(i));
      assign line_now[i] = |(raw_q & mask_q & line_sel(i));
   end

   if (REG_OUT) begin : g_reg
      logic [LINE_N-1:0] irq_q;
      logic              unused_now;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= '0;
         else        irq_q <= line_nx;
      end
      assign unused_now = ^line_now;
      assign irq_o      = irq_q;
   end else begin : g_comb
      logic unused_nx;
      logic unused_clk;
      assign unused_nx  = ^line_nx;
      assign unused_clk = clk ^ rst_n;
      assign irq_o      = line_now;
   end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 32,
   parameter int IDX_MASK = 14,
   parameter int IDX_RAW  = 15,
   parameter int IDX_MSKD = 16,
   parameter int IDX_CLR  = 17,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [10:0]       set_i,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [5:0]        irq_o
);

   localparam int IDX_MAX = 1 << ADDR_W;

   if (DATA_W <= SRC_W) begin : g_bad_data
      $error("DATA_W must exceed the source count");
   end
   if (IDX_CLR >= IDX_MAX || IDX_MSKD >= IDX_MAX ||
       IDX_RAW >= IDX_MAX || IDX_MASK >= IDX_MAX) begin : g_bad_addr
      $error("register index does not fit ADDR_W");
   end
   if (IDX_MASK == IDX_RAW || IDX_MASK == IDX_MSKD || IDX_MASK == IDX_CLR ||
       IDX_RAW == IDX_MSKD || IDX_RAW == IDX_CLR || IDX_MSKD == IDX_CLR) begin : g_bad_map
      $error("register indices must be distinct");
   end

   src_vec_t raw_d, raw_q, mask_d, mask_q, clr_vec;

   uart_irq_raw u_raw (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_i),
      .clr_vec (clr_vec),
      .raw_d   (raw_d),
      .raw_q   (raw_q)
   );

   uart_irq_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .IDX_MASK (IDX_MASK),
      .IDX_RAW  (IDX_RAW),
      .IDX_MSKD (IDX_MSKD),
      .IDX_CLR  (IDX_CLR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .raw_q     (raw_q),
      .mask_d    (mask_d),
      .mask_q    (mask_q),
      .clr_vec   (clr_vec),
      .bus_rdata (bus_rdata)
   );

   uart_irq_lines #(
      .REG_OUT (REG_OUT)
   ) u_lines (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_d  (raw_d),
      .mask_d (mask_d),
      .raw_q  (raw_q),
      .mask_q (mask_q),
      .irq_o  (irq_o)
   );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 32,
   parameter int IDX_MASK = 14,
   parameter int IDX_CLR  = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic [10:0]       set_i,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [10:0]       raw_q,
   input logic [10:0]       mask_q,
   input logic [5:0]        irq_o
);

   logic clr_wr, msk_wr;
   assign clr_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(IDX_CLR);
   assign msk_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(IDX_MASK);

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (raw_q == '0 && mask_q == '0 && irq_o == '0));

   // R4 is covered too: a strobed bit is set even under a clear
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i)));

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((raw_q & $past(bus_wdata[10:0] & ~set_i)) == '0));

   p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      msk_wr |=> (mask_q == $past(bus_wdata[10:0])));

   p_line0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[0] == |(raw_q & mask_q));

   p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[5] == |(raw_q & mask_q & 11'h780));

   p_modem_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[4] == |(raw_q & mask_q & 11'h00f));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && !clr_wr && !msk_wr) |=> $stable(irq_o));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .IDX_MASK (IDX_MASK),
   .IDX_CLR  (IDX_CLR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .set_i     (set_i),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .raw_q     (raw_q),
   .mask_q    (mask_q),
   .irq_o     (irq_o)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] set_i = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  irq_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural model state
   int unsigned m_raw = 0;
   int unsigned m_mask = 0;

   always #2 clk = ~clk;

   uart_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .set_i(set_i), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [5:0] exp_lines(input int unsigned r, input int unsigned m);
      int unsigned e;
      e = r & m;
      exp_lines[0] = (e & 32'h7ff) != 0;
      exp_lines[1] = e[4];
      exp_lines[2] = e[5];
      exp_lines[3] = e[6];
      exp_lines[4] = (e & 32'h00f) != 0;
      exp_lines[5] = (e & 32'h780) != 0;
   endfunction

   function automatic int unsigned exp_read(input int a);
      if (a == 14) return m_mask;
      if (a == 15) return m_raw;
      if (a == 16) return m_raw & m_mask;
      return 0;
   endfunction

   task automatic check(input string req, input int unsigned act, input int unsigned exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_lines(input string tag);
      logic [5:0] e;
      e = exp_lines(m_raw, m_mask);
      check({tag, " R6 line0"}, 32'(irq_o[0]), 32'(e[0]));
      check({tag, " R7 lines1-5"}, 32'(irq_o[5:1]), 32'(e[5:1]));
   endtask

   // one bus cycle plus strobes; entered and left at a falling edge
   task automatic step(input logic [10:0] s, input bit sel, input bit wr,
                       input int a, input logic [31:0] wd);
      set_i = s; bus_sel = sel; bus_wr = wr; bus_addr = 10'(a); bus_wdata = wd;
      #1;
      if (sel && !wr) begin
         if (a == 14 || a == 16) check("R5 read", bus_rdata, exp_read(a));
         else if (a == 15)       check("R2 read", bus_rdata, exp_read(a));
         else                    check("R9 read", bus_rdata, exp_read(a));
      end else begin
         check("R9 idle read", bus_rdata, 0);
      end
      @(posedge clk);
      if (sel && wr && a == 17) m_raw = m_raw & ~(wd & 32'h7ff);
      m_raw = m_raw | 32'(s);
      if (sel && wr && a == 14) m_mask = wd & 32'h7ff;
      @(negedge clk);
      set_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
      check_lines("R8");
   endtask

   task automatic rd(input int a);
      step('0, 1'b1, 1'b0, a, '0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_fail++;
         $display("[TB] FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 lines", 32'(irq_o), 0);
      rd(15); rd(14); rd(16);

      // R2 set with mask zero: stored, no line
      step(11'h010, 0, 0, 0, '0);
      rd(15);
      check("R1 masked line quiet", 32'(irq_o), 0);
      // R5 mask write with upper bits, R8 line follows directly
      step('0, 1, 1, 14, 32'hffff_f810);
      check("R8 receive line after mask write", 32'(irq_o), 32'h03);
      rd(14); rd(16);
      // R9 writes to read-only indices ignored
      step('0, 1, 1, 15, 32'h0);
      step('0, 1, 1, 16, 32'h0);
      rd(15);
      rd(17); rd(3);
      // R7 groups
      step('0, 1, 1, 14, 32'h7ff);
      step(11'h002, 0, 0, 0, '0);
      check("R7 modem line", 32'(irq_o[4]), 1);
      step(11'h200, 0, 0, 0, '0);
      check("R7 error line", 32'(irq_o[5]), 1);
      // R3 partial clear
      step('0, 1, 1, 17, 32'h0000_0012);
      rd(15);
      check("R3 modem cleared", 32'(irq_o[4]), 0);
      // R4 set beats clear on same bit
      step(11'h020, 1, 1, 17, 32'h0000_0220);
      rd(15);
      check("R4 transmit kept", 32'(irq_o[2]), 1);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         int unsigned r;
         logic [10:0] s;
         int a;
         r = $urandom;
         s = (r[3:0] == 0) ? 11'($urandom) : ((r[5:4] == 0) ? 11'(1 << (r[9:6] % 11)) : '0);
         a = (r[12:10] < 6) ? 14 + int'(r[12:10] % 4) : int'(r[20:13] % 24);
         step(s, r[21] | r[22], r[23], a, $urandom);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule